// File: doc/BRIEF.md
# Multi-Page-Size Translation Buffer

This block is a fully associative translation buffer that turns a 32-bit effective address into a physical address in one registered clock. Each stored entry has its own page size: 4 KiB, 16 KiB, 512 KiB or 8 MiB. Each entry also holds an address-space tag, a sharing flag and one of 16 access groups. Its attribute bits are write-through, cache-inhibit, guarded and changed. A 4 KiB entry also holds four 1 KiB subpage enable bits. All entries are compared in parallel. The lowest-index match is used.

A lookup returns exactly one of three results: a hit with the physical address and attributes, a miss, or an error. An error means that an entry matched but the access is refused. Software fills the buffer one entry at a time through a load port, and a victim pointer chooses the slot in round-robin order. The same software can drop one page or every entry. When translation is off, the address passes straight through and the cache attributes come from two default inputs.

Top module: `xlat_tlb`

## Requirements
- R1: After reset no entry is valid, the victim pointer is 0, and all response outputs are 0. A lookup then reports a miss.
- R2: Each entry's size code picks its compare mask: 0 is 4 KiB (bits 31:12), 1 is 16 KiB (bits 31:14), 2 is 512 KiB (bits 31:19), 3 is 8 MiB (bits 31:23). On a hit the physical address is the entry's physical bits above the mask joined with the effective-address bits below it.
- R3: For a 4 KiB entry, subpage enable bit ea[11:10] must be 1. Otherwise the lookup reports an error and not a miss. Subpage bits are ignored for the other sizes.
- R4: An entry matches only when its 4-bit space tag equals `cur_space` or its shared flag is 1.
- R5: With `mgr_mode`=0, protection bit 0 permits reads and bit 1 permits writes. A refused access reports an error.
- R6: With `mgr_mode`=1, the 2-bit code of the entry's group (`grp_ovr[2g+1:2g]`) decides access. Code 00 refuses every access, code 11 permits every access, and codes 01 and 10 fall back to the page protection bits.
- R7: A write that matches an entry whose changed bit is 0 reports an error. The entry itself is not modified.
- R8: A hit returns the entry's write-through, cache-inhibit and guarded bits. A miss or an error returns address 0 and attributes 0.
- R9: With `xlat_en`=0 a lookup always hits. The physical address then equals the effective address, write-through and cache-inhibit come from `dflt_wt` and `dflt_ci`, and guarded is 0.
- R10: A lookup that matches no valid entry reports a miss. Each response raises exactly one of hit, miss or error.
- R11: Each load writes the slot at the victim pointer. The pointer then advances by one and wraps after the last slot, so an entry survives 31 further loads and is replaced by the 32nd.
- R12: `inv_op` codes are 0 none, 1 page, 2 all and 3 sync. Page clears every entry whose masked page contains `inv_ea`, whatever its space tag. All clears every entry. Sync changes nothing. An invalidate affects lookups from the next clock on; a lookup in the same cycle sees the old contents.
- R13: The response appears on the clock edge after the lookup is issued. When several entries match, the lowest index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xlat_en | input | 1 | Translation enable |
| mgr_mode | input | 1 | 1 selects group-override protection |
| cur_space | input | 4 | Current address-space identifier |
| grp_ovr | input | 32 | 2-bit override code per group |
| dflt_wt | input | 1 | Write-through used when translation is off |
| dflt_ci | input | 1 | Cache-inhibit used when translation is off |
| lk_valid | input | 1 | Lookup request |
| lk_ea | input | 32 | Lookup effective address |
| lk_write | input | 1 | Lookup is a data write |
| ld_en | input | 1 | Load an entry at the victim slot |
| ld_ea | input | 32 | Effective page address of the loaded entry |
| ld_pa | input | 32 | Physical page address of the loaded entry |
| ld_size | input | 2 | Page size code |
| ld_space | input | 4 | Space tag |
| ld_shared | input | 1 | Entry matches any space |
| ld_grp | input | 4 | Access group |
| ld_pp | input | 2 | Page protection (bit0 read, bit1 write) |
| ld_wt | input | 1 | Write-through attribute |
| ld_ci | input | 1 | Cache-inhibit attribute |
| ld_g | input | 1 | Guarded attribute |
| ld_chg | input | 1 | Changed bit |
| ld_sub | input | 4 | 1 KiB subpage enables |
| inv_op | input | 2 | Invalidate command |
| inv_ea | input | 32 | Address for a page invalidate |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No entry matched |
| rsp_err | output | 1 | Entry matched, access refused |
| rsp_pa | output | 32 | Physical address |
| rsp_wt | output | 1 | Write-through |
| rsp_ci | output | 1 | Cache-inhibit |
| rsp_g | output | 1 | Guarded |

## Verification
A lookup and an invalidate can be issued in the same cycle. The bench drives a page invalidate together with a lookup that falls inside that same 16 KiB page. The lookup must still hit with the old translation, and a repeat of it one clock later must miss. Issuing a sync with a lookup and an invalidate-all followed by lookups also confirms which entries survive each command.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int EA_W    = 32;
  localparam int SPACE_W = 4;
  localparam int GRP_W   = 4;
  localparam int NGRP    = 1 << GRP_W;
  localparam int SUB_LSB = 10;

  typedef enum logic [1:0] {PG_4K = 2'd0, PG_16K = 2'd1, PG_512K = 2'd2, PG_8M = 2'd3} pg_size_e;
  typedef enum logic [1:0] {INV_NONE = 2'd0, INV_PAGE = 2'd1, INV_ALL = 2'd2, INV_SYNC = 2'd3} inv_op_e;

  typedef struct packed {
    logic               vld;
    logic [EA_W-1:0]    ea;
    logic [EA_W-1:0]    pa;
    pg_size_e           size;
    logic [SPACE_W-1:0] space;
    logic               shared;
    logic [GRP_W-1:0]   grp;
    logic [1:0]         pp;
    logic               wt;
    logic               ci;
    logic               g;
    logic               chg;
    logic [3:0]         sub;
  } tlb_ent_t;

  function automatic logic [EA_W-1:0] page_mask(pg_size_e s);
    case (s)
      PG_4K:   return 32'hFFFF_F000;
      PG_16K:  return 32'hFFFF_C000;
      PG_512K: return 32'hFFF8_0000;
      default: return 32'hFF80_0000;
    endcase
  endfunction
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
  import xlat_pkg::*;
#(
  parameter int N = 32
) (
  input  tlb_ent_t              ents [N],
  input  logic [EA_W-1:0]       ea,
  input  logic [SPACE_W-1:0]    space,
  input  logic                  chk_space,
  output logic [N-1:0]          match
);
  for (genvar i = 0; i < N; i++) begin : g_ent
    logic [EA_W-1:0] msk;
    logic            space_ok;
    assign msk      = page_mask(ents[i].size);
    assign space_ok = !chk_space || ents[i].shared || (ents[i].space == space);
    assign match[i] = ents[i].vld && space_ok && ((ea & msk) == (ents[i].ea & msk));
  end
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
  parameter int N  = 32,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  match,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) begin
        idx = IW'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
  import xlat_pkg::*;
(
  input  tlb_ent_t   ent,
  input  logic [1:0] sub_idx,
  input  logic       wr,
  input  logic       mgr_mode,
  input  logic [1:0] grp_code,
  output logic       deny
);
  logic sub_bad, page_ok, acc_ok, chg_bad;

  always_comb begin
    sub_bad = (ent.size == PG_4K) && !ent.sub[sub_idx];
    page_ok = wr ? ent.pp[1] : ent.pp[0];
    acc_ok  = page_ok;
    if (mgr_mode) begin
      case (grp_code)
        2'b00:   acc_ok = 1'b0;
        2'b11:   acc_ok = 1'b1;
        default: acc_ok = page_ok;
      endcase
    end
    chg_bad = wr && !ent.chg;
    deny    = sub_bad || !acc_ok || chg_bad;
  end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xlat_pkg::*;
#(
  parameter int N = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               xlat_en,
  input  logic               mgr_mode,
  input  logic [SPACE_W-1:0] cur_space,
  input  logic [2*NGRP-1:0]  grp_ovr,
  input  logic               dflt_wt,
  input  logic               dflt_ci,
  input  logic               lk_valid,
  input  logic [EA_W-1:0]    lk_ea,
  input  logic               lk_write,
  input  logic               ld_en,
  input  logic [EA_W-1:0]    ld_ea,
  input  logic [EA_W-1:0]    ld_pa,
  input  logic [1:0]         ld_size,
  input  logic [SPACE_W-1:0] ld_space,
  input  logic               ld_shared,
  input  logic [GRP_W-1:0]   ld_grp,
  input  logic [1:0]         ld_pp,
  input  logic               ld_wt,
  input  logic               ld_ci,
  input  logic               ld_g,
  input  logic               ld_chg,
  input  logic [3:0]         ld_sub,
  input  logic [1:0]         inv_op,
  input  logic [EA_W-1:0]    inv_ea,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic               rsp_miss,
  output logic               rsp_err,
  output logic [EA_W-1:0]    rsp_pa,
  output logic               rsp_wt,
  output logic               rsp_ci,
  output logic               rsp_g
);
  localparam int IW = $clog2(N);

  tlb_ent_t        ents [N];
  logic [IW-1:0]   victim;
  logic [N-1:0]    lk_match, inv_match, vld_vec;
  logic [IW-1:0]   hit_idx;
  logic            hit_any, deny;
  tlb_ent_t        sel, new_ent;
  logic [EA_W-1:0] sel_mask;
  inv_op_e         op;

  assign op = inv_op_e'(inv_op);

  for (genvar i = 0; i < N; i++) begin : g_vld
    assign vld_vec[i] = ents[i].vld;
  end

  always_comb begin
    new_ent        = '0;
    new_ent.vld    = 1'b1;
    new_ent.ea     = ld_ea;
    new_ent.pa     = ld_pa;
    new_ent.size   = pg_size_e'(ld_size);
    new_ent.space  = ld_space;
    new_ent.shared = ld_shared;
    new_ent.grp    = ld_grp;
    new_ent.pp     = ld_pp;
    new_ent.wt     = ld_wt;
    new_ent.ci     = ld_ci;
    new_ent.g      = ld_g;
    new_ent.chg    = ld_chg;
    new_ent.sub    = ld_sub;
  end

  // Entry store: a load fills the victim slot; invalidates clear valid bits last.
  always_ff @(posedge clk) begin
    if (rst) begin
      victim <= '0;
      for (int i = 0; i < N; i++) ents[i].vld <= 1'b0;
    end else begin
      if (ld_en) begin
        ents[victim] <= new_ent;
        victim       <= (victim == IW'(N - 1)) ? '0 : victim + 1'b1;
      end
      for (int i = 0; i < N; i++) begin
        if (op == INV_ALL || (op == INV_PAGE && inv_match[i])) ents[i].vld <= 1'b0;
      end
    end
  end

  tlb_cam #(.N(N)) u_lk_cam (
    .ents(ents), .ea(lk_ea), .space(cur_space), .chk_space(1'b1), .match(lk_match));

  tlb_cam #(.N(N)) u_inv_cam (
    .ents(ents), .ea(inv_ea), .space(cur_space), .chk_space(1'b0), .match(inv_match));

  tlb_pick #(.N(N)) u_pick (.match(lk_match), .idx(hit_idx), .any(hit_any));

  assign sel      = ents[hit_idx];
  assign sel_mask = page_mask(sel.size);

  tlb_perm u_perm (
    .ent(sel), .sub_idx(lk_ea[SUB_LSB+1:SUB_LSB]), .wr(lk_write), .mgr_mode(mgr_mode),
    .grp_code(grp_ovr[2*sel.grp +: 2]), .deny(deny));

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0; rsp_hit <= 1'b0; rsp_miss <= 1'b0; rsp_err <= 1'b0;
      rsp_pa    <= '0;   rsp_wt  <= 1'b0; rsp_ci   <= 1'b0; rsp_g   <= 1'b0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit <= 1'b0; rsp_miss <= 1'b0; rsp_err <= 1'b0;
      rsp_pa  <= '0;   rsp_wt   <= 1'b0; rsp_ci  <= 1'b0; rsp_g <= 1'b0;
      if (lk_valid) begin
        if (!xlat_en) begin
          rsp_hit <= 1'b1; rsp_pa <= lk_ea; rsp_wt <= dflt_wt; rsp_ci <= dflt_ci;
        end else if (!hit_any) begin
          rsp_miss <= 1'b1;
        end else if (deny) begin
          rsp_err <= 1'b1;
        end else begin
          rsp_hit <= 1'b1;
          rsp_pa  <= (sel.pa & sel_mask) | (lk_ea & ~sel_mask);
          rsp_wt  <= sel.wt; rsp_ci <= sel.ci; rsp_g <= sel.g;
        end
      end
    end
  end

  // Assertions
  p_one_result_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_err}) == 1);
  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !rsp_hit && !rsp_miss && !rsp_err);
  p_nomatch_miss_r10: assert property (@(posedge clk) disable iff (rst)
    lk_valid && xlat_en && !(|lk_match) |=> rsp_miss);
  p_off_pass_r9: assert property (@(posedge clk) disable iff (rst)
    lk_valid && !xlat_en |=> rsp_hit && rsp_pa == $past(lk_ea));
  p_clean_write_r7: assert property (@(posedge clk) disable iff (rst)
    lk_valid && xlat_en && lk_write && hit_any && !ents[hit_idx].chg |=> rsp_err);
  p_victim_step_r11: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> victim == (($past(victim) == IW'(N - 1)) ? '0 : $past(victim) + 1'b1));
  p_flush_all_r12: assert property (@(posedge clk) disable iff (rst)
    op == INV_ALL |=> vld_vec == '0);
  p_lowest_r13: assert property (@(posedge clk) disable iff (rst)
    hit_any |-> lk_match[hit_idx] && ((lk_match & ((N'(1) << hit_idx) - N'(1))) == '0));
endmodule

// File: tb/sim_xlat_tlb.sv
`timescale 1ns/1ps
module sim_xlat_tlb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        xlat_en = 1'b1, mgr_mode = 1'b0;
  logic [3:0]  cur_space = '0;
  logic [31:0] grp_ovr = 32'h5555_5555;
  logic        dflt_wt = 1'b0, dflt_ci = 1'b0;
  logic        lk_valid = 1'b0, lk_write = 1'b0;
  logic [31:0] lk_ea = '0;
  logic        ld_en = 1'b0;
  logic [31:0] ld_ea = '0, ld_pa = '0;
  logic [1:0]  ld_size = '0, ld_pp = '0;
  logic [3:0]  ld_space = '0, ld_grp = '0, ld_sub = '0;
  logic        ld_shared = 1'b0, ld_wt = 1'b0, ld_ci = 1'b0, ld_g = 1'b0, ld_chg = 1'b0;
  logic [1:0]  inv_op = '0;
  logic [31:0] inv_ea = '0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_err, rsp_wt, rsp_ci, rsp_g;
  logic [31:0] rsp_pa;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  xlat_tlb u0 (.*);

  typedef struct packed {
    logic [31:0] ea; logic wr; logic [3:0] sp;
    logic [2:0]  res;   // {hit, miss, err}
    logic [31:0] pa; logic [2:0] attr; logic [3:0] req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{32'h1000_0123, 1'b0, 4'd3, 3'b100, 32'h0020_0123, 3'b100, 4'd2},  // R2 4K hit
    '{32'h1000_0A45, 1'b0, 4'd3, 3'b001, 32'h0,         3'b000, 4'd3},  // R3 subpage 2 off
    '{32'h1000_0C00, 1'b1, 4'd3, 3'b100, 32'h0020_0C00, 3'b100, 4'd3},  // R3 subpage 3 on
    '{32'h1000_0123, 1'b0, 4'd4, 3'b010, 32'h0,         3'b000, 4'd4},  // R4 wrong space
    '{32'h2000_3ABC, 1'b0, 4'd3, 3'b100, 32'h0040_3ABC, 3'b011, 4'd8},  // R8 16K attrs
    '{32'h2000_4000, 1'b0, 4'd3, 3'b010, 32'h0,         3'b000, 4'd10}, // R10 past 16K
    '{32'h2000_0010, 1'b1, 4'd3, 3'b001, 32'h0,         3'b000, 4'd5},  // R5 read-only
    '{32'h3007_FFFF, 1'b0, 4'd9, 3'b100, 32'h0087_FFFF, 3'b000, 4'd4},  // R4 shared 512K
    '{32'h3008_0000, 1'b0, 4'd9, 3'b010, 32'h0,         3'b000, 4'd2},  // R2 past 512K
    '{32'h3000_0004, 1'b1, 4'd0, 3'b001, 32'h0,         3'b000, 4'd7},  // R7 unchanged page
    '{32'h4000_0010, 1'b0, 4'd5, 3'b100, 32'h0180_0010, 3'b111, 4'd13}, // R13 lowest index
    '{32'h407F_FFFC, 1'b0, 4'd5, 3'b100, 32'h01FF_FFFC, 3'b111, 4'd2},  // R2 8M top
    '{32'h4080_0000, 1'b0, 4'd5, 3'b010, 32'h0,         3'b000, 4'd10}  // R10 past 8M
  };

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(logic [31:0] ea, logic [31:0] pa, logic [1:0] sz, logic [3:0] sp,
                      logic sh, logic [3:0] grp, logic [1:0] pp, logic [2:0] attr,
                      logic chg, logic [3:0] sub);
    ld_en = 1'b1; ld_ea = ea; ld_pa = pa; ld_size = sz; ld_space = sp; ld_shared = sh;
    ld_grp = grp; ld_pp = pp; {ld_wt, ld_ci, ld_g} = attr; ld_chg = chg; ld_sub = sub;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic lookup(logic [31:0] ea, logic wr, logic [3:0] sp);
    lk_valid = 1'b1; lk_ea = ea; lk_write = wr; cur_space = sp;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic expect_rsp(string req, logic [2:0] res, logic [31:0] pa, logic [2:0] attr);
    check(req, {29'd0, rsp_hit, rsp_miss, rsp_err, rsp_pa}, {29'd0, res, pa});
    check(req, {61'd0, rsp_wt, rsp_ci, rsp_g}, {61'd0, attr});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: quiet outputs, empty buffer
    check("R1", {56'd0, rsp_valid, rsp_hit, rsp_miss, rsp_err, rsp_wt, rsp_ci, rsp_g, 1'b0}, 64'd0);
    lookup(32'h1000_0000, 1'b0, 4'd3);
    expect_rsp("R1", 3'b010, 32'h0, 3'b000);

    // Fill five slots (R11 victim 0..4)
    load(32'h1000_0000, 32'h0020_0000, 2'd0, 4'd3, 1'b0, 4'd1, 2'b11, 3'b100, 1'b1, 4'b1011);
    load(32'h2000_0000, 32'h0040_0000, 2'd1, 4'd3, 1'b0, 4'd2, 2'b01, 3'b011, 1'b1, 4'b1111);
    load(32'h3000_0000, 32'h0080_0000, 2'd2, 4'd0, 1'b1, 4'd3, 2'b11, 3'b000, 1'b0, 4'b0000);
    load(32'h4000_0000, 32'h0180_0000, 2'd3, 4'd5, 1'b0, 4'd4, 2'b11, 3'b111, 1'b1, 4'b1111);
    load(32'h4000_0000, 32'h0F00_0000, 2'd0, 4'd5, 1'b0, 4'd4, 2'b11, 3'b000, 1'b1, 4'b1111);

    for (int i = 0; i < NV; i++) begin
      lookup(VECS[i].ea, VECS[i].wr, VECS[i].sp);
      check($sformatf("R%0d vec%0d", VECS[i].req, i),
            {29'd0, rsp_hit, rsp_miss, rsp_err, rsp_pa}, {29'd0, VECS[i].res, VECS[i].pa});
      check($sformatf("R%0d vec%0d attr", VECS[i].req, i),
            {61'd0, rsp_wt, rsp_ci, rsp_g}, {61'd0, VECS[i].attr});
    end

    // R6: group override in manager mode (grp2=11, grp1=00, grp3=01)
    mgr_mode = 1'b1; grp_ovr = 32'h5555_5571;
    lookup(32'h2000_0010, 1'b1, 4'd3);
    expect_rsp("R6 full", 3'b100, 32'h0040_0010, 3'b011);
    lookup(32'h1000_0123, 1'b0, 4'd3);
    expect_rsp("R6 deny", 3'b001, 32'h0, 3'b000);
    lookup(32'h3000_0000, 1'b0, 4'd0);
    expect_rsp("R6 page", 3'b100, 32'h0080_0000, 3'b000);
    mgr_mode = 1'b0;

    // R9: translation off
    xlat_en = 1'b0; dflt_wt = 1'b1; dflt_ci = 1'b0;
    lookup(32'h1234_5678, 1'b1, 4'd7);
    expect_rsp("R9", 3'b100, 32'h1234_5678, 3'b100);
    xlat_en = 1'b1;

    // R12: page invalidate in the same cycle as a lookup in that page
    inv_op = 2'd1; inv_ea = 32'h2000_2000;
    lookup(32'h2000_0100, 1'b0, 4'd3);
    inv_op = 2'd0;
    expect_rsp("R12 same-cycle", 3'b100, 32'h0040_0100, 3'b011);
    lookup(32'h2000_0100, 1'b0, 4'd3);
    expect_rsp("R12 after page", 3'b010, 32'h0, 3'b000);
    inv_op = 2'd3;
    lookup(32'h1000_0000, 1'b0, 4'd3);
    inv_op = 2'd0;
    lookup(32'h1000_0000, 1'b0, 4'd3);
    expect_rsp("R12 sync", 3'b100, 32'h0020_0000, 3'b100);
    inv_op = 2'd2;
    @(negedge clk);
    inv_op = 2'd0;
    lookup(32'h1000_0000, 1'b0, 4'd3);
    expect_rsp("R12 all", 3'b010, 32'h0, 3'b000);
    lookup(32'h4000_0010, 1'b0, 4'd5);
    expect_rsp("R12 all 8M", 3'b010, 32'h0, 3'b000);

    // R11: entry survives 31 loads, replaced by the 32nd
    load(32'h5000_0000, 32'h0A00_0000, 2'd0, 4'd0, 1'b1, 4'd0, 2'b11, 3'b000, 1'b1, 4'b1111);
    for (int k = 0; k < 31; k++)
      load(32'h6000_0000 + (k << 12), 32'h0, 2'd0, 4'd0, 1'b1, 4'd0, 2'b11, 3'b000, 1'b1, 4'b1111);
    lookup(32'h5000_0040, 1'b0, 4'd0);
    expect_rsp("R11 kept", 3'b100, 32'h0A00_0040, 3'b000);
    load(32'h7000_0000, 32'h0, 2'd0, 4'd0, 1'b1, 4'd0, 2'b11, 3'b000, 1'b1, 4'b1111);
    lookup(32'h5000_0040, 1'b0, 4'd0);
    expect_rsp("R11 replaced", 3'b010, 32'h0, 3'b000);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule